// File: doc/BRIEF.md
# Presettable up/down counter with terminal-count outputs

A four-bit synchronous counter that steps once per rising clock edge, upward or downward, and can be preset at any time from a four-bit data bus. A build-time parameter selects the sequence: a full modulo-16 binary count, or a decade count that cycles through 0 to 9. Preset is asynchronous and active low. While it is asserted, the outputs show the data bus directly. An active-low enable gates counting, and a synchronous active-high reset clears the state.

Two indicator outputs support cascading. `term_cnt` is a level flag decoded from the present value and the direction input. It is raised at the last value of the sequence in the current direction, and it does not depend on the enable. `carry_n` is an active-low pulse. It is driven low during the low phase of the clock when the stage is enabled and at its terminal value, so it can serve as the clock or the enable of a following stage. Driving the enable high suppresses this pulse.

Top module: `updn_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `din` at once, whatever the clock, the enable and the reset do. The preset value stays in the state after `load_n` returns high.
- R2: With `load_n` high, a rising edge with `rst` high clears the state to 0.
- R3: With `load_n` high and `rst` low, a rising edge with `cnt_en_n` high leaves the state unchanged.
- R4: In the binary variant (`DECADE`=0), an enabled edge adds 1 when `down` is 0 and subtracts 1 when `down` is 1. The count wraps from 15 to 0 going up and from 0 to 15 going down.
- R5: In the decade variant (`DECADE`=1), counting up goes from 9 to 0, counting down goes from 0 to 9, and a count that starts in 0 to 9 stays in 0 to 9.
- R6: In the decade variant, a preset value from 10 to 15 counts up by 1, with 15 going to 0, and counts down by 1.
- R7: In the binary variant, `term_cnt` is 1 exactly when `count` is 15 with `down`=0, or when `count` is 0 with `down`=1.
- R8: In the decade variant, `term_cnt` is 1 exactly when bit 0 and bit 3 of `count` are both 1 with `down`=0, or when `count` is 0 with `down`=1. In both variants `term_cnt` ignores `cnt_en_n` and follows a change of `down` without a clock edge.
- R9: `carry_n` is 0 only while `clk` is low, `cnt_en_n` is low and `term_cnt` is 1. It is 1 throughout the high phase of the clock.
- R10: `cnt_en_n` high forces `carry_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Asynchronous preset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | 4 | Preset value |
| count | output | 4 | Counter value |
| term_cnt | output | 1 | Terminal-value flag for the current direction |
| carry_n | output | 1 | Active-low cascade pulse in the low clock phase |

## Verification
Both variants are built side by side and receive the same stimulus. The stimulus consists of a full wrap in each direction, presets of the illegal decade values 10 to 15 followed by counting in both directions, a preset held across a clock edge while its data changes, held counts with the enable high, and direction flips at the terminal value. Random runs then mix all inputs. Preset and reset are kept rare so that long count runs occur and reach the wrap points.

Each edge is checked twice. The first sample is in the low clock phase, after new inputs are applied: this is where the preset, the direction-driven change of `term_cnt` and the `carry_n` pulse become visible. The second sample follows the rising edge, where `carry_n` must be high and the counted value must appear. Together the two samples separate a gated pulse from a level, and a preset that overrides the edge from a preset that only competes with it.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  localparam int CNT_W = 4;
  localparam int DEC_TOP = 9;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/updn_next.sv
module updn_next
  import updn_cnt_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  cnt_t cur,
  input  logic down,
  output cnt_t nxt
);
  localparam cnt_t TOP = cnt_t'(DEC_TOP);

  generate
    if (DECADE) begin : g_dec
      always_comb begin
        if (down) nxt = (cur == '0) ? TOP : cur - cnt_t'(1);
        else      nxt = (cur == TOP) ? '0 : cur + cnt_t'(1);
      end
    end else begin : g_bin
      always_comb nxt = down ? cur - cnt_t'(1) : cur + cnt_t'(1);
    end
  endgenerate
endmodule

// File: rtl/updn_tc.sv
module updn_tc
  import updn_cnt_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  cnt_t cur,
  input  logic down,
  output logic tc
);
  logic at_top;

  generate
    if (DECADE) begin : g_dec
      assign at_top = cur[0] & cur[CNT_W-1];
    end else begin : g_bin
      assign at_top = &cur;
    end
  endgenerate

  assign tc = down ? (cur == '0) : at_top;
endmodule

// File: rtl/updn_rc.sv
module updn_rc (
  input  logic clk,
  input  logic en_n,
  input  logic tc,
  output logic rc_n
);
  assign rc_n = ~(~en_n & tc & ~clk);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_cnt_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             down,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] count,
  output logic             term_cnt,
  output logic             carry_n
);
  cnt_t state_q;
  cnt_t step_val;

  updn_next #(.DECADE(DECADE)) u_next (
    .cur  (state_q),
    .down (down),
    .nxt  (step_val)
  );

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)        state_q <= din;
    else if (rst)       state_q <= '0;
    else if (!cnt_en_n) state_q <= step_val;
  end

  assign count = load_n ? state_q : din;

  updn_tc #(.DECADE(DECADE)) u_tc (
    .cur  (count),
    .down (down),
    .tc   (term_cnt)
  );

  updn_rc u_rc (
    .clk  (clk),
    .en_n (cnt_en_n),
    .tc   (term_cnt),
    .rc_n (carry_n)
  );

  // R2: clear on the edge after reset, unless preset intervenes
  p_reset_r2: assert property (@(posedge clk)
    (rst && load_n) |=> (!load_n || count == '0));

  // R3: disabled edge holds the value
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (load_n && cnt_en_n) |=> (!load_n || count == $past(count)));

  // R4: ordinary up step away from wrap points
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_en_n && !down && count != cnt_t'(DEC_TOP) && count != '1)
    |=> (!load_n || count == $past(count) + cnt_t'(1)));

  // R9: a low carry only with enable low and terminal flag seen
  p_carry_src_r9: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (!cnt_en_n && term_cnt));

  generate
    if (DECADE) begin : g_dec_chk
      // R5: legal decade values never leave 0..9 by counting
      p_dec_range_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && count <= cnt_t'(DEC_TOP)) |=> (!load_n || count <= cnt_t'(DEC_TOP)));
    end
  endgenerate
endmodule

// File: tb/updn_counter_bench.sv
module updn_counter_bench;
  localparam int CLK_P = 10;
  localparam int NRAND = 600;

  logic clk = 1'b0;
  logic rst = 1'b1, load_n = 1'b1, cnt_en_n = 1'b1, down = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt_b, cnt_d;
  logic tc_b, tc_d, rc_b, rc_d;
  int n_chk = 0, n_bad = 0;
  logic [3:0] mb, md;
  bit valid = 0;

  always #(CLK_P/2) clk = ~clk;

  updn_counter #(.DECADE(1'b0)) u_updn_counter (
    .clk(clk), .rst(rst), .load_n(load_n), .cnt_en_n(cnt_en_n), .down(down),
    .din(din), .count(cnt_b), .term_cnt(tc_b), .carry_n(rc_b));

  updn_counter #(.DECADE(1'b1)) u_updn_counter_dec (
    .clk(clk), .rst(rst), .load_n(load_n), .cnt_en_n(cnt_en_n), .down(down),
    .din(din), .count(cnt_d), .term_cnt(tc_d), .carry_n(rc_d));

  function automatic logic [3:0] nxt_f(logic [3:0] s, logic dn, bit dec);
    if (dec) begin
      if (dn) return (s == 0) ? 4'd9 : s - 4'd1;
      return (s == 9) ? 4'd0 : s + 4'd1;
    end
    return dn ? s - 4'd1 : s + 4'd1;
  endfunction

  function automatic logic tc_f(logic [3:0] s, logic dn, bit dec);
    if (dn) return s == 0;
    return dec ? (s[0] & s[3]) : (s == 4'd15);
  endfunction

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_low(string tb, string td);
    logic [3:0] eb, ed;
    eb = load_n ? mb : din;
    ed = load_n ? md : din;
    chk(tb, "bin count", cnt_b, eb);
    chk(td, "dec count", cnt_d, ed);
    chk("R7", "bin tc", {3'b0, tc_b}, {3'b0, tc_f(eb, down, 0)});
    chk("R8", "dec tc", {3'b0, tc_d}, {3'b0, tc_f(ed, down, 1)});
    chk(cnt_en_n ? "R10" : "R9", "bin carry low phase", {3'b0, rc_b},
        {3'b0, ~(~cnt_en_n & tc_f(eb, down, 0))});
    chk(cnt_en_n ? "R10" : "R9", "dec carry low phase", {3'b0, rc_d},
        {3'b0, ~(~cnt_en_n & tc_f(ed, down, 1))});
  endtask

  task automatic check_high(string tb, string td);
    chk(tb, "bin count", cnt_b, mb);
    chk(td, "dec count", cnt_d, md);
    chk("R9", "bin carry high phase", {3'b0, rc_b}, 4'd1);
    chk("R9", "dec carry high phase", {3'b0, rc_d}, 4'd1);
  endtask

  task automatic cyc(logic r, logic ld, logic en, logic dn, logic [3:0] d,
                     string tb, string td);
    @(negedge clk);
    rst = r; load_n = ld; cnt_en_n = en; down = dn; din = d;
    #1;
    if (valid) check_low(tb, td);
    @(posedge clk);
    if (!ld) begin mb = d; md = d; end
    else if (r) begin mb = 0; md = 0; end
    else if (!en) begin mb = nxt_f(mb, dn, 0); md = nxt_f(md, dn, 1); end
    valid = 1;
    #1;
    check_high(tb, td);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0191));
    mb = 'x; md = 'x;
    cyc(1, 1, 1, 0, 4'd7, "R2", "R2");
    cyc(0, 1, 1, 0, 4'd7, "R3", "R3");
    // full upward wrap in both variants
    for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0, 4'd0, "R4", "R5");
    // full downward wrap
    for (int i = 0; i < 18; i++) cyc(0, 1, 0, 1, 4'd0, "R4", "R5");
    // hold with enable high at a terminal value, direction flips
    cyc(0, 0, 1, 1, 4'd0, "R1", "R1");
    cyc(0, 1, 1, 0, 4'd0, "R10", "R10");
    cyc(0, 1, 1, 1, 4'd0, "R10", "R10");
    cyc(0, 1, 0, 1, 4'd0, "R9", "R9");
    // illegal decade presets, up and down
    for (int v = 10; v < 16; v++) begin
      cyc(0, 0, 1, 0, 4'(v), "R1", "R1");
      cyc(0, 1, 0, 0, 4'd0, "R4", "R6");
      cyc(0, 0, 1, 0, 4'(v), "R1", "R1");
      cyc(0, 1, 0, 1, 4'd0, "R4", "R6");
    end
    // preset overrides clock and reset; data changes while preset held
    @(negedge clk);
    load_n = 0; din = 4'd3; cnt_en_n = 0; rst = 1; down = 0;
    #1 chk("R1", "bin preset follows", cnt_b, 4'd3);
    din = 4'd6;
    #1 chk("R1", "dec preset follows", cnt_d, 4'd6);
    @(posedge clk); #1;
    chk("R1", "bin preset beats edge", cnt_b, 4'd6);
    chk("R1", "dec preset beats edge", cnt_d, 4'd6);
    mb = 6; md = 6;
    cyc(0, 1, 0, 0, 4'd0, "R1", "R1");
    cyc(0, 1, 1, 0, 4'd0, "R3", "R3");
    // random mix
    for (int i = 0; i < NRAND; i++) begin
      logic r, ld, en, dn;
      logic [3:0] d;
      r  = ($urandom % 40) == 0;
      ld = ($urandom % 12) != 0;
      en = ($urandom % 5) == 0;
      dn = ($urandom % 8) < 3 ? ~down : down;
      d  = 4'($urandom);
      cyc(r, ld, en, dn, d, ld ? (r ? "R2" : (en ? "R3" : "R4")) : "R1",
          ld ? (r ? "R2" : (en ? "R3" : "R5")) : "R1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule